// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter. On every clock it presents a trial code to an external DAC. It reads back one comparator bit that says whether the analog input lies above the DAC level. It then narrows the code by binary search, deciding one bit per clock from the most significant bit down. When the least significant bit has been decided, the finished code is copied into a separate result register, together with a one-cycle valid pulse. The result register then holds that value while the next conversion runs.

The start input is active low and is sampled only on a rising clock edge. While it is held low, the sequencer stays at the opening guess. The search begins on the first edge at which start is seen high. The active-low done output falls when the result is captured. It rises again on the edge that loads the opening guess of the next conversion. Wiring done back to start therefore makes the converter run continuously, with one conversion every nine clocks.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no start seen, `conv_done_n` is 1, `trial_code` is 0, `result` is 0 and `result_valid` is 0.
- R2: A low pulse on `start_n` that begins and ends between two rising clock edges changes nothing: `trial_code` and `conv_done_n` keep their values.
- R3: On every rising edge at which `start_n` is low, `trial_code` becomes the opening guess, with the MSB 0 and all other bits 1 (127 for 8 bits), and `conv_done_n` becomes 1. It stays there for as long as `start_n` stays low.
- R4: On each edge after start is released, the comparator bit (1 = input above the DAC level) is written into the bit under test. The next lower bit is cleared and the bits below it stay 1. After k such edges, `trial_code` holds the decided upper k bits, then a 0, then all ones.
- R5: `conv_done_n` stays 1 for the 7 edges after start is released and falls on the 8th. That is the ninth edge counting the start edge. A comparator that reports input > trial yields a final code equal to the input value.
- R6: `conv_done_n` falls on the edge that captures the result, and rises only on an edge that loads the opening guess.
- R7: `result` loads the completed code, including the corrected LSB, on the edge on which `conv_done_n` falls. `result_valid` is high for exactly that one cycle, and `result` does not change at any other time.
- R8: With `start_n` driven from `conv_done_n`, a new conversion starts immediately after each one finishes. `result_valid` pulses every 9 cycles, each time with the correct code.
- R9: Asserting `start_n` in the middle of a search abandons it and reloads the opening guess on that edge.
- R10: After a conversion finishes, with `start_n` high, `trial_code` holds the final code and `conv_done_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_n | input | 1 | Active-low start / hold-in-initialise, sampled on the clock edge |
| cmp_gt | input | 1 | Comparator result: 1 when the analog input exceeds the DAC level |
| trial_code | output | 8 | Code currently driven to the DAC |
| conv_done_n | output | 1 | Active-low conversion complete |
| result | output | 8 | Captured result of the latest finished conversion |
| result_valid | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The opening guess appears one edge after `start_n` is seen low. The k-th search step shows up one edge after the k-th released edge. `conv_done_n`, `result` and `result_valid` all change together on the eighth released edge. The bench drives inputs on the falling edge and samples on the next falling edge. Each expected trial code is therefore compared exactly one register stage after the edge that made it. A sweep over all 256 input levels checks every intermediate code against a value computed arithmetically from the input. In free-running mode the bench counts falling edges between valid pulses and expects exactly nine.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } sar_phase_e;

endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = shift_q[STAGES-1];

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_n,
  input  logic         cmp_gt,
  output logic [W-1:0] trial,
  output logic         done_n,
  output logic         load,
  output logic [W-1:0] final_code
);

  localparam int          IW   = $clog2(W);
  localparam logic [W-1:0] INIT = {1'b0, {(W-1){1'b1}}};
  localparam logic [IW-1:0] TOP = IW'(W-1);

  sar_phase_e    ph_q, ph_d;
  logic [W-1:0]  code_q, code_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          done_q, done_d;
  logic          step_en;

  assign step_en = !start_n || (ph_q == PH_RUN);

  always_comb begin
    code_d = code_q;
    idx_d  = idx_q;
    ph_d   = ph_q;
    done_d = done_q;
    load   = 1'b0;
    if (!start_n) begin
      code_d = INIT;
      idx_d  = TOP;
      ph_d   = PH_RUN;
      done_d = 1'b1;
    end else if (ph_q == PH_RUN) begin
      code_d[idx_q] = cmp_gt;
      if (idx_q != '0) begin
        code_d[idx_q - 1'b1] = 1'b0;
        idx_d = idx_q - 1'b1;
      end else begin
        ph_d   = PH_DONE;
        done_d = 1'b0;
        load   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      idx_q  <= '0;
      ph_q   <= PH_IDLE;
      done_q <= 1'b1;
    end else if (step_en) begin
      code_q <= code_d;
      idx_q  <= idx_d;
      ph_q   <= ph_d;
      done_q <= done_d;
    end
  end

  assign trial      = code_q;
  assign done_n     = done_q;
  assign final_code = code_d;

  AST_INIT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n |=> (trial == INIT && done_n)); // R3

  AST_CC_RISE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_n) |-> (trial == INIT)); // R6

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DONE && start_n) |=> ($stable(trial) && !done_n)); // R10

  AST_STEP_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RUN && start_n && idx_q != '0) |=> ($countones(trial ^ $past(trial)) <= 2)); // R4

endmodule

// File: rtl/sar_capture.sv
module sar_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] result,
  output logic         valid
);

  logic [W-1:0] res_q;
  logic         vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= load;
      if (load) begin
        res_q <= code_in;
      end
    end
  end

  assign result = res_q;
  assign valid  = vld_q;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(result)); // R7

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_n,
  input  logic         cmp_gt,
  output logic [W-1:0] trial_code,
  output logic         conv_done_n,
  output logic [W-1:0] result,
  output logic         result_valid
);

  logic         srst_n;
  logic         load;
  logic [W-1:0] final_code;

  sar_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sar_seq #(.W(W)) u_seq (
    .clk        (clk),
    .rst_n      (srst_n),
    .start_n    (start_n),
    .cmp_gt     (cmp_gt),
    .trial      (trial_code),
    .done_n     (conv_done_n),
    .load       (load),
    .final_code (final_code)
  );

  sar_capture #(.W(W)) u_cap (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (load),
    .code_in (final_code),
    .result  (result),
    .valid   (result_valid)
  );

  AST_CC_FALL_VALID: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(conv_done_n) |-> result_valid); // R6

  AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!srst_n)
    result_valid |-> (!conv_done_n && result == trial_code)); // R7

endmodule

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, btn_n, selfmode;
  int           vin;
  logic         start_n, cmp_gt;
  logic [W-1:0] trial_code, result;
  logic         conv_done_n, result_valid;

  assign start_n = btn_n & (selfmode ? conv_done_n : 1'b1);
  assign cmp_gt  = (vin > int'(trial_code));

  sar_adc_ctrl #(.W(W)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_n      (start_n),
    .cmp_gt       (cmp_gt),
    .trial_code   (trial_code),
    .conv_done_n  (conv_done_n),
    .result       (result),
    .result_valid (result_valid)
  );

  int total = 0;
  int fails = 0;

  task automatic chk_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input int v);
    int exp;
    @(negedge clk);
    vin = v; btn_n = 1'b0;
    @(negedge clk);
    chk_eq("R3 opening guess", int'(trial_code), (1 << (W-1)) - 1);
    chk_eq("R6 done high at opening guess", int'(conv_done_n), 1);
    btn_n = 1'b1;
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      if (k < W) begin
        exp = (v & ~((1 << (W-k)) - 1) & ((1 << W) - 1)) | ((1 << (W-1-k)) - 1);
        chk_eq("R4 search step", int'(trial_code), exp);
        chk_eq("R5 done still high", int'(conv_done_n), 1);
        chk_eq("R7 no valid mid-search", int'(result_valid), 0);
      end else begin
        chk_eq("R5 done falls on ninth edge", int'(conv_done_n), 0);
        chk_eq("R5 final code equals input", int'(result), v);
        chk_eq("R7 valid pulse", int'(result_valid), 1);
      end
    end
    @(negedge clk);
    chk_eq("R7 valid one cycle", int'(result_valid), 0);
    chk_eq("R7 result held", int'(result), v);
    chk_eq("R10 done stays low", int'(conv_done_n), 0);
    chk_eq("R10 trial holds final", int'(trial_code), v);
  endtask

  initial begin
    rst_n = 1'b0; btn_n = 1'b1; selfmode = 1'b0; vin = 0;
    repeat (3) @(negedge clk);
    chk_eq("R1 done in reset", int'(conv_done_n), 1);
    chk_eq("R1 trial in reset", int'(trial_code), 0);
    chk_eq("R1 result in reset", int'(result), 0);
    chk_eq("R1 valid in reset", int'(result_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R1 idle done", int'(conv_done_n), 1);
    chk_eq("R1 idle trial", int'(trial_code), 0);
    chk_eq("R1 idle valid", int'(result_valid), 0);

    // R2: glitch between edges while idle
    #1 btn_n = 1'b0;
    #1 btn_n = 1'b1;
    @(negedge clk);
    chk_eq("R2 idle glitch trial", int'(trial_code), 0);
    chk_eq("R2 idle glitch done", int'(conv_done_n), 1);

    // R3: start held low for several clocks
    btn_n = 1'b0; vin = 200;
    repeat (4) begin
      @(negedge clk);
      chk_eq("R3 held start trial", int'(trial_code), (1 << (W-1)) - 1);
      chk_eq("R3 held start done", int'(conv_done_n), 1);
    end
    btn_n = 1'b1;

    // R4, R5, R7, R10: exhaustive sweep of input levels
    for (int v = 0; v < (1 << W); v++) begin
      run_conv(v);
    end

    // R2: glitch while done
    #1 btn_n = 1'b0;
    #1 btn_n = 1'b1;
    @(negedge clk);
    chk_eq("R2 done glitch trial", int'(trial_code), (1 << W) - 1);
    chk_eq("R2 done glitch done", int'(conv_done_n), 0);

    // R9: restart in mid-search
    vin = 200; btn_n = 1'b0;
    @(negedge clk);
    btn_n = 1'b1;
    repeat (3) @(negedge clk);
    vin = 55; btn_n = 1'b0;
    @(negedge clk);
    chk_eq("R9 restart trial", int'(trial_code), (1 << (W-1)) - 1);
    chk_eq("R9 restart done", int'(conv_done_n), 1);
    chk_eq("R9 result untouched", int'(result), (1 << W) - 1);
    btn_n = 1'b1;
    run_conv(55);

    // R8: free-running with done tied to start
    vin = 17; selfmode = 1'b1;
    for (int i = 0; i < 16; i++) begin
      int cnt;
      cnt = 0;
      do begin
        @(negedge clk);
        cnt++;
      end while (!result_valid && cnt < 40);
      chk_eq("R8 period", cnt, 9);
      chk_eq("R8 result", int'(result), vin);
      vin = (i * 37 + 11) % (1 << W);
    end
    selfmode = 1'b0;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule